// File: doc/BRIEF.md
# E1 Receive Alarm and Error Counters

This block watches the recovered receive bit stream of an E1 line and keeps three alarm flags up to date: loss of carrier (long runs of zeros), alarm indication signal (an almost all-ones stream), and remote alarm (the far-end alarm bit carried in the non-alignment frame). Each flag has its own rule for being raised and a separate rule for being dropped. This gives hysteresis, so a marginal line does not make the flag toggle on every bit.

Next to the alarms, four performance counters record code violations, CRC4 errors, far-end block errors reported in the E bits, and frame alignment word errors. The line decoder and the framer supply these events as single-cycle strobes. The counters run over a measurement interval, which the block times itself from the bit-rate enable and which can be long (one second) or short (one sixteenth of that). At each interval boundary the counts are copied into read-only snapshot registers and the live counters start again from zero. Software reads a snapshot through a two-bit select and a 16-bit read-data bus. All activity advances only on cycles where the bit-rate enable is high, so the block can run from a fast system clock.

Top module: `e1_rx_perf_mon`

## Requirements
- R1: After reset all three alarm flags are 0 and all four snapshot registers read 0.
- R2: With `cfg_rcl_long`=0, `carrier_lost` rises in the cycle after the 255th consecutive zero bit. After 254 consecutive zeros it is still 0.
- R3: With `cfg_rcl_long`=1, `carrier_lost` needs 2048 consecutive zeros. After 2047 zeros it is still 0, and it rises after the 2048th.
- R4: Enabled bits are grouped into consecutive 255-bit windows counted from reset. At the end of a window that held at least 32 ones, `carrier_lost` clears. A window with 31 ones leaves it set.
- R5: Enabled bits are also grouped into consecutive 512-bit windows counted from reset. At the end of each window, `ais_detected` becomes 1 if the window held at most 2 zeros and 0 otherwise. It changes at no other time.
- R6: A bit marked by `nfas_bit3_mark` is a remote-alarm sample. Three consecutive marked samples of 1 set `remote_alarm`, and three consecutive marked samples of 0 clear it. Any shorter run leaves it unchanged.
- R7: Each strobe increments its live counter once per enabled bit. At an interval boundary the count, including that bit's strobe, becomes the snapshot, and the live counter restarts from 0. `rd_sel` selects the snapshot: 0 code violations, 1 CRC4 errors, 2 E-bit errors, 3 FAS errors. Each value is zero-extended to 16 bits.
- R8: The counters saturate at all ones instead of wrapping. They are 16 bits (code violations), 10 bits (CRC4), 10 bits (E bits) and 12 bits (FAS).
- R9: The interval is `SHORT_BITS` enabled bits when `cfg_short_interval`=1 and `LONG_BITS` otherwise. It is counted from reset, and by default the two values are 128,000 and 2,048,000.
- R10: A snapshot does not change between interval boundaries.
- R11: In cycles where `bit_en` is 0, all data, marker and strobe inputs are ignored: no alarm, window, counter or interval state advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle enable per received bit (2.048 MHz rate) |
| rx_bit | input | 1 | Decoded receive data bit |
| nfas_bit3_mark | input | 1 | High when `rx_bit` is bit 3 of a non-alignment frame |
| cv_pulse | input | 1 | Bipolar or code violation strobe |
| crc_err_pulse | input | 1 | CRC4 code word error strobe |
| ebit_pulse | input | 1 | Far-end E-bit error strobe |
| fas_err_pulse | input | 1 | Frame alignment word error strobe |
| cfg_rcl_long | input | 1 | 1 selects the 2048-zero carrier loss threshold |
| cfg_short_interval | input | 1 | 1 selects the short counter interval |
| rd_sel | input | 2 | Snapshot select |
| rd_data | output | 16 | Selected snapshot, zero-extended |
| carrier_lost | output | 1 | Loss of carrier alarm |
| ais_detected | output | 1 | All-ones alarm |
| remote_alarm | output | 1 | Remote alarm flag |

## Verification
Carrier loss is driven with zero runs one short of each threshold and exactly at each threshold, which separates the normal and long modes. The clear rule is tried with windows holding 31 and 32 ones, which pins the boundary of the ones count. The all-ones alarm sees windows with zero, two and three zeros, so the at-most-two rule is separated from an off-by-one. Remote-alarm samples are given as broken runs and as complete runs. The counters receive sparse strobes of different densities in one short interval, which tells the four channels and their select codes apart. They then receive dense strobes over one long interval, where the 10-bit counters saturate and the 12-bit and 16-bit counters do not. A long stall with the enable low and every input active shows that nothing moves outside enabled bits.

// File: rtl/e1_mon_pkg.sv
package e1_mon_pkg;
    localparam int RD_W    = 16;
    localparam int NUM_CNT = 4;

    typedef enum logic [1:0] {
        SEL_CV   = 2'd0,
        SEL_CRC  = 2'd1,
        SEL_EBIT = 2'd2,
        SEL_FAS  = 2'd3
    } cnt_sel_e;
endpackage

// File: rtl/e1_line_alarm_det.sv
module e1_line_alarm_det #(
    parameter int RCL_RUN       = 255,
    parameter int RCL_RUN_ALT   = 2048,
    parameter int RCL_WIN       = 255,
    parameter int RCL_MIN_ONES  = 32,
    parameter int AIS_WIN       = 512,
    parameter int AIS_MAX_ZEROS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic rcl_long,
    output logic carrier_lost,
    output logic ais_all_ones
);
    localparam int ZW = $clog2(RCL_RUN_ALT + 1);
    localparam int LW = $clog2(RCL_WIN);
    localparam int OW = $clog2(RCL_WIN + 1);
    localparam int AW = $clog2(AIS_WIN);
    localparam int AZ = $clog2(AIS_MAX_ZEROS + 2);
    localparam logic [ZW-1:0] Z_SHORT   = ZW'(RCL_RUN);
    localparam logic [ZW-1:0] Z_LONG    = ZW'(RCL_RUN_ALT);
    localparam logic [LW-1:0] LPOS_LAST = LW'(RCL_WIN - 1);
    localparam logic [OW-1:0] ONES_MIN  = OW'(RCL_MIN_ONES);
    localparam logic [AW-1:0] APOS_LAST = AW'(AIS_WIN - 1);
    localparam logic [AZ-1:0] AZ_LIM    = AZ'(AIS_MAX_ZEROS);
    localparam logic [AZ-1:0] AZ_CAP    = AZ'(AIS_MAX_ZEROS + 1);

    typedef struct packed {
        logic [ZW-1:0] zrun;
        logic [LW-1:0] lpos;
        logic [OW-1:0] lones;
        logic [AW-1:0] apos;
        logic [AZ-1:0] azeros;
        logic          rcl;
        logic          ais;
    } det_st_t;

    det_st_t st_d, st_q;
    logic [OW-1:0] ones_n;
    logic [AZ-1:0] zeros_n;

    always_comb begin
        st_d    = st_q;
        ones_n  = st_q.lones + OW'(rx_bit);
        zeros_n = (st_q.azeros == AZ_CAP) ? st_q.azeros : st_q.azeros + AZ'(!rx_bit);
        if (bit_en) begin
            // zero run, capped at the longer threshold
            if (rx_bit)                   st_d.zrun = '0;
            else if (st_q.zrun != Z_LONG) st_d.zrun = st_q.zrun + 1'b1;
            // ones count over a fixed window, for clearing
            if (st_q.lpos == LPOS_LAST) begin
                st_d.lpos  = '0;
                st_d.lones = '0;
                if (ones_n >= ONES_MIN) st_d.rcl = 1'b0;
            end else begin
                st_d.lpos  = st_q.lpos + 1'b1;
                st_d.lones = ones_n;
            end
            if (st_d.zrun >= (rcl_long ? Z_LONG : Z_SHORT)) st_d.rcl = 1'b1;
            // zero count over a two-frame window
            if (st_q.apos == APOS_LAST) begin
                st_d.apos   = '0;
                st_d.azeros = '0;
                st_d.ais    = (zeros_n <= AZ_LIM);
            end else begin
                st_d.apos   = st_q.apos + 1'b1;
                st_d.azeros = zeros_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carrier_lost = st_q.rcl;
    assign ais_all_ones = st_q.ais;

    AST_RCL_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rcl) |-> $past(bit_en && !rx_bit)); // R2
    AST_AIS_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.ais) || $fell(st_q.ais)) |-> $past(bit_en)); // R5
endmodule

// File: rtl/e1_rai_det.sv
module e1_rai_det #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic mark,
    input  logic rx_bit,
    output logic remote_alarm
);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [RW-1:0] RUN_FULL = RW'(RUN_LEN);

    typedef struct packed {
        logic          last;
        logic [RW-1:0] run;
        logic          rai;
    } rai_st_t;

    rai_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_en && mark) begin
            if (rx_bit == st_q.last && st_q.run != '0)
                st_d.run = (st_q.run == RUN_FULL) ? st_q.run : st_q.run + 1'b1;
            else
                st_d.run = RW'(1);
            st_d.last = rx_bit;
            if (st_d.run == RUN_FULL) st_d.rai = rx_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign remote_alarm = st_q.rai;

    AST_RAI_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rai) |-> $past(bit_en && mark && rx_bit)); // R6
    AST_RAI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.rai) |-> $past(bit_en && mark && !rx_bit)); // R6
endmodule

// File: rtl/e1_interval_tmr.sv
module e1_interval_tmr #(
    parameter int LONG_BITS  = 2048000,
    parameter int SHORT_BITS = 128000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic short_sel,
    output logic tick
);
    localparam int CW = $clog2(LONG_BITS + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_BITS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_BITS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // >= so a switch to the short interval mid-count ends it at once
        tick = bit_en && (st_q.cnt >= (short_sel ? SHORT_LAST : LONG_LAST));
        if (tick)        st_d.cnt = '0;
        else if (bit_en) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(st_q.cnt)); // R11
endmodule

// File: rtl/e1_sat_cnt.sv
module e1_sat_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         evt,
    input  logic         restart,
    output logic [W-1:0] snap
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] live;
        logic [W-1:0] snap;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [W-1:0] inc;

    always_comb begin
        st_d = st_q;
        inc  = (bit_en && evt && st_q.live != MAXV) ? st_q.live + 1'b1 : st_q.live;
        if (restart) begin
            st_d.snap = inc;
            st_d.live = '0;
        end else begin
            st_d.live = inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap = st_q.snap;

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live == MAXV && !restart) |=> st_q.live == MAXV); // R8
    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(st_q.snap)); // R10
endmodule

// File: rtl/e1_rx_perf_mon.sv
module e1_rx_perf_mon
    import e1_mon_pkg::*;
#(
    parameter int LONG_BITS  = 2048000,
    parameter int SHORT_BITS = 128000,
    parameter int CV_W       = 16,
    parameter int CRC_W      = 10,
    parameter int EBIT_W     = 10,
    parameter int FAS_W      = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            rx_bit,
    input  logic            nfas_bit3_mark,
    input  logic            cv_pulse,
    input  logic            crc_err_pulse,
    input  logic            ebit_pulse,
    input  logic            fas_err_pulse,
    input  logic            cfg_rcl_long,
    input  logic            cfg_short_interval,
    input  logic [1:0]      rd_sel,
    output logic [RD_W-1:0] rd_data,
    output logic            carrier_lost,
    output logic            ais_detected,
    output logic            remote_alarm
);
    logic                           tick;
    logic [NUM_CNT-1:0]             evt;
    logic [NUM_CNT-1:0][RD_W-1:0]   snap_ext;

    assign evt = {fas_err_pulse, ebit_pulse, crc_err_pulse, cv_pulse};

    e1_line_alarm_det u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .rx_bit       (rx_bit),
        .rcl_long     (cfg_rcl_long),
        .carrier_lost (carrier_lost),
        .ais_all_ones (ais_detected)
    );

    e1_rai_det u_rai (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .mark         (nfas_bit3_mark),
        .rx_bit       (rx_bit),
        .remote_alarm (remote_alarm)
    );

    e1_interval_tmr #(
        .LONG_BITS  (LONG_BITS),
        .SHORT_BITS (SHORT_BITS)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .short_sel (cfg_short_interval),
        .tick      (tick)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam int W = (g == int'(SEL_CV))  ? CV_W  :
                           (g == int'(SEL_CRC)) ? CRC_W :
                           (g == int'(SEL_EBIT)) ? EBIT_W : FAS_W;
        logic [W-1:0] snap;

        e1_sat_cnt #(.W(W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .bit_en  (bit_en),
            .evt     (evt[g]),
            .restart (tick),
            .snap    (snap)
        );

        assign snap_ext[g] = RD_W'(snap);
    end

    assign rd_data = snap_ext[rd_sel];
endmodule

// File: tb/e1_rx_perf_mon_tb.sv
`timescale 1ns/1ps
module e1_rx_perf_mon_tb_top;
    localparam int LONG_T  = 2400;
    localparam int SHORT_T = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0, rx_bit = 1'b1, mark = 1'b0;
    logic        cv = 1'b0, crc = 1'b0, eb = 1'b0, fas = 1'b0;
    logic        cfg_rcl_long = 1'b0, cfg_short = 1'b1;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        carrier_lost, ais_detected, remote_alarm;

    int n_checks = 0;
    int n_err    = 0;
    int nbits    = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    e1_rx_perf_mon #(.LONG_BITS(LONG_T), .SHORT_BITS(SHORT_T)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .nfas_bit3_mark(mark), .cv_pulse(cv), .crc_err_pulse(crc),
        .ebit_pulse(eb), .fas_err_pulse(fas), .cfg_rcl_long(cfg_rcl_long),
        .cfg_short_interval(cfg_short), .rd_sel(rd_sel), .rd_data(rd_data),
        .carrier_lost(carrier_lost), .ais_detected(ais_detected),
        .remote_alarm(remote_alarm)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_bit(input bit b, input bit m = 0, input bit c = 0,
                             input bit r = 0, input bit e = 0, input bit f = 0);
        @(negedge clk);
        bit_en = 1'b1; rx_bit = b; mark = m; cv = c; crc = r; eb = e; fas = f;
        @(posedge clk);
        #1;
        bit_en = 1'b0; mark = 1'b0; cv = 1'b0; crc = 1'b0; eb = 1'b0; fas = 1'b0;
        nbits++;
    endtask

    task automatic drive_n(input int cnt, input bit b);
        for (int i = 0; i < cnt; i++) drive_bit(b);
    endtask

    task automatic align(input int m, input bit b);
        while (nbits % m != 0) drive_bit(b);
    endtask

    task automatic chk_snaps(input string req, input int v0, input int v1,
                             input int v2, input int v3);
        int exp_v [4];
        exp_v = '{v0, v1, v2, v3};
        for (int s = 0; s < 4; s++) begin
            rd_sel = s[1:0];
            #0.5;
            chk($sformatf("%s sel%0d", req, s), int'(rd_data), exp_v[s]);
        end
    endtask

    task automatic test_reset;
        chk("R1 carrier", int'(carrier_lost), 0);
        chk("R1 ais", int'(ais_detected), 0);
        chk("R1 rai", int'(remote_alarm), 0);
        chk_snaps("R1 snap", 0, 0, 0, 0);
    endtask

    task automatic test_ais;
        drive_n(511, 1);
        chk("R5 before window end", int'(ais_detected), 0);
        drive_bit(1);
        chk("R5 all ones window", int'(ais_detected), 1);
        for (int i = 0; i < 512; i++) drive_bit(!(i == 100 || i == 300));
        chk("R5 two zeros keeps", int'(ais_detected), 1);
        for (int i = 0; i < 511; i++) drive_bit(!(i == 10 || i == 200 || i == 400));
        chk("R5 no change mid window", int'(ais_detected), 1);
        drive_bit(1);
        chk("R5 three zeros clears", int'(ais_detected), 0);
        drive_n(512, 1);
        chk("R5 sets again", int'(ais_detected), 1);
    endtask

    task automatic test_rcl_normal;
        drive_bit(1);
        drive_n(254, 0);
        chk("R2 254 zeros", int'(carrier_lost), 0);
        drive_bit(0);
        chk("R2 255 zeros", int'(carrier_lost), 1);
    endtask

    task automatic test_rcl_clear;
        align(255, 0);
        drive_n(31, 1);
        drive_n(224, 0);
        chk("R4 31 ones keeps", int'(carrier_lost), 1);
        drive_n(32, 1);
        drive_n(222, 0);
        chk("R4 mid window", int'(carrier_lost), 1);
        drive_bit(0);
        chk("R4 32 ones clears", int'(carrier_lost), 0);
        drive_n(40, 1);
    endtask

    task automatic test_rcl_alt;
        cfg_rcl_long = 1'b1;
        drive_n(2047, 0);
        chk("R3 2047 zeros", int'(carrier_lost), 0);
        drive_bit(0);
        chk("R3 2048 zeros", int'(carrier_lost), 1);
        drive_n(510, 1);
        chk("R4 ones clear after long", int'(carrier_lost), 0);
        cfg_rcl_long = 1'b0;
    endtask

    task automatic rai_sample(input bit b);
        drive_bit(b, 1'b1);
        drive_n(3, 1);
    endtask

    task automatic test_rai;
        rai_sample(1); rai_sample(1);
        chk("R6 two ones", int'(remote_alarm), 0);
        rai_sample(1);
        chk("R6 three ones", int'(remote_alarm), 1);
        rai_sample(0); rai_sample(0); rai_sample(1);
        chk("R6 broken zeros", int'(remote_alarm), 1);
        rai_sample(0); rai_sample(0);
        chk("R6 two zeros", int'(remote_alarm), 1);
        rai_sample(0);
        chk("R6 three zeros", int'(remote_alarm), 0);
    endtask

    task automatic test_counters_short;
        align(SHORT_T, 1);
        for (int i = 0; i < SHORT_T; i++) begin
            if (i == 50) begin
                // R11: long stall with every input active
                @(negedge clk);
                rx_bit = 1'b0; mark = 1'b1; cv = 1'b1; crc = 1'b1; eb = 1'b1; fas = 1'b1;
                repeat (300) @(posedge clk);
                #1;
                mark = 1'b0; cv = 1'b0; crc = 1'b0; eb = 1'b0; fas = 1'b0;
                chk("R11 no carrier loss while idle", int'(carrier_lost), 0);
                chk("R11 rai unchanged while idle", int'(remote_alarm), 0);
            end
            drive_bit(1, 0, i % 20 == 0, i % 50 == 3, i % 30 == 7, i % 16 == 1);
        end
        chk_snaps("R7 short interval", 8, 3, 5, 10);
        drive_n(SHORT_T / 2, 1);
        chk_snaps("R10 held mid interval", 8, 3, 5, 10);
        drive_n(SHORT_T - SHORT_T / 2, 1);
        chk_snaps("R7 restart from zero", 0, 0, 0, 0);
    endtask

    task automatic test_counters_long;
        cfg_short = 1'b0;
        for (int i = 0; i < LONG_T; i++) begin
            drive_bit(1, 0, 1, 1, 1, 1);
            if (i == 199) chk_snaps("R9 no short tick", 0, 0, 0, 0);
            if (i == LONG_T - 2) chk_snaps("R9 before long end", 0, 0, 0, 0);
        end
        chk_snaps("R8 saturation widths", LONG_T, 1023, 1023, LONG_T);
        cfg_short = 1'b1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        test_reset();
        test_ais();
        test_rcl_normal();
        test_rcl_clear();
        test_rcl_alt();
        test_rai();
        test_counters_short();
        test_counters_long();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule